// File: doc/BRIEF.md
# Timer break-source combiner

This block collects the fault signals that can stop a timer's outputs and turns them into one active-high break request. There are three selectable break sources: a dedicated fault pin and two comparator outputs. Each source is brought into the block clock domain through a two-flop synchronizer. Its active level is then set by its own invert bit together with a shared global break polarity input, and it is gated by its enable bit. The enabled sources are ORed with an already synchronous "other break" input. The result is registered once and driven on `brk_req`.

The block also picks the timer's external trigger from six candidates: a legacy pin, the two comparator outputs and three ADC analog-watchdog flags. A 3-bit selector chooses among them.

A small option register holds the enables, the invert bits and the selector. A simple bus writes and reads it. A non-zero lock level input freezes the register, so the configuration cannot change after it has been committed.

Top module: `brk_src_merge`

## Requirements
- R1: After reset the option register reads 0 (all sources disabled, no inversion, selector 0), `brk_req` is 0, and `ext_trg` follows `trg_pin`.
- R2: Option register layout: bit 0 enables the fault pin, bit 1 enables comparator 1, bit 2 enables comparator 2. Bits 3, 4 and 5 invert the fault pin, comparator 1 and comparator 2 in that order. Bits 8:6 hold the trigger selector. When `wr_en` is high and `lock_lvl` is 0, the register takes `wr_data` on that clock edge, and `rd_data` shows the new value from then on.
- R3: While `lock_lvl` is non-zero, writes are ignored and every field keeps its value.
- R4: A source whose enable bit is 0 never raises `brk_req`, whatever its level.
- R5: An enabled source counts as active when its input level equals `glob_pol` XOR its invert bit.
- R6: `brk_req` is the OR of all enabled active sources and `other_brk`. Any single one of them is enough to raise it.
- R7: A change on `flt_pin`, `cmp1_out` or `cmp2_out` reaches `brk_req` on the third rising edge after it. A change on `other_brk` reaches `brk_req` on the first rising edge after it.
- R8: Selector code 0 routes `trg_pin` to `ext_trg`. Code 1 routes `cmp1_out` and code 2 routes `cmp2_out`. Codes 3, 4 and 5 route `awd_flag[0]`, `awd_flag[1]` and `awd_flag[2]`. The path is combinational.
- R9: A write whose selector field is 6 or 7 leaves the stored selector unchanged, but still updates the enable and invert fields.
- R10: `rd_data` always shows the stored register, whatever the lock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Register write value |
| rd_data | output | 9 | Current register contents |
| lock_lvl | input | 2 | Lock level; non-zero freezes the register |
| glob_pol | input | 1 | Global break polarity |
| flt_pin | input | 1 | Asynchronous dedicated fault pin |
| cmp1_out | input | 1 | Asynchronous comparator 1 output |
| cmp2_out | input | 1 | Asynchronous comparator 2 output |
| other_brk | input | 1 | Synchronous active-high break from other sources |
| trg_pin | input | 1 | Legacy external trigger pin |
| awd_flag | input | 3 | ADC analog-watchdog flags |
| brk_req | output | 1 | Registered combined break request |
| ext_trg | output | 1 | Selected external trigger |

## Verification
Each result comes due after a fixed number of cycles:
- A register write shows on `rd_data` one edge after the strobe.
- A fault-pin or comparator level shows on `brk_req` three edges after it is driven.
- `other_brk` shows on `brk_req` one edge after it is driven.
- `ext_trg` follows its selected source within the same cycle.

The bench drives inputs just after a rising edge, waits exactly that many edges and samples 1 ns later. For R7 it also samples one edge early to show that the request has not yet moved. Configuration and `glob_pol` settle well before any fault level is applied, so only the path under test sets the timing of each check.

// File: rtl/brk_merge_pkg.sv
// Package: shared sizes, register layout and selector codes for the
// break-source combiner. Assumes three break sources and three watchdog flags.
package brk_merge_pkg;
    localparam int N_SRC   = 3;
    localparam int N_AWD   = 3;
    localparam int SEL_W   = 3;
    localparam int CFG_W   = 2 * N_SRC + SEL_W;
    localparam int N_TRG   = 3 + N_AWD;      // legacy pin, two comparators, watchdogs
    localparam int SEL_MAX = N_TRG - 1;      // highest legal selector code

    // Option register, packed so the LSB is the fault-pin enable.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [N_SRC-1:0] inv;
        logic [N_SRC-1:0] en;
    } brk_cfg_t;
endpackage

// File: rtl/brk_sync.sv
// Multi-stage synchronizer for asynchronous fault levels.
// Assumes STAGES >= 2; clears to 0 on reset.
module brk_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/brk_cfg_reg.sv
// Option register with lock protection and reserved-code filtering.
// Assumes any non-zero lock level blocks every field.
module brk_cfg_reg
    import brk_merge_pkg::*;
#(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  brk_cfg_t          wr_cfg,
    input  logic [LOCK_W-1:0] lock_lvl,
    output brk_cfg_t          cfg_q
);
    logic locked;
    logic sel_ok;

    // Decode the lock and the legality of the requested selector.
    assign locked = (lock_lvl != '0);
    assign sel_ok = (int'(wr_cfg.sel) <= SEL_MAX);

    // Update the fields on an unlocked write; keep the selector on a reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && !locked) begin
            cfg_q.en  <= wr_cfg.en;
            cfg_q.inv <= wr_cfg.inv;
            if (sel_ok) cfg_q.sel <= wr_cfg.sel;
        end
    end

    // R3: a locked cycle never changes the register.
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && locked) |=> $stable(cfg_q));

    // R2: an unlocked legal write is stored exactly.
    p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !locked && sel_ok) |=> (cfg_q == $past(wr_cfg)));

    // R9: a reserved selector code is never held.
    p_no_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_q.sel) <= SEL_MAX));
endmodule

// File: rtl/brk_src_cond.sv
// Polarity conditioning, enable gating and OR merge of the break sources.
// Assumes synchronous inputs; the output is combinational.
module brk_src_cond #(
    parameter int N = 3
) (
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] en,
    input  logic [N-1:0] inv,
    input  logic         glob_pol,
    input  logic         other,
    output logic         req
);
    logic [N-1:0] hit;

    // Per source: active level = glob_pol ^ inv, match by XNOR, then gate.
    for (genvar i = 0; i < N; i++) begin : g_src
        logic act_hi;
        assign act_hi = glob_pol ^ inv[i];
        assign hit[i] = en[i] & ~(lvl[i] ^ act_hi);
    end

    // Merge every conditioned source with the external break.
    assign req = (|hit) | other;
endmodule

// File: rtl/brk_trg_mux.sv
// External trigger selector; reserved codes yield 0.
// Assumes the candidate vector is ordered by selector code.
module brk_trg_mux #(
    parameter int N     = 6,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N-1:0]     cand,
    output logic             trg
);
    // Pick the candidate whose index equals the selector code.
    always_comb begin
        trg = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(sel) == i) trg = cand[i];
        end
    end
endmodule

// File: rtl/brk_src_merge.sv
// Top: break-source combiner with lockable option register and trigger select.
// Assumes flt_pin/cmp1_out/cmp2_out are asynchronous and other_brk is synchronous.
module brk_src_merge
    import brk_merge_pkg::*;
#(
    parameter int LOCK_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  rd_data,
    input  logic [LOCK_W-1:0] lock_lvl,
    input  logic              glob_pol,
    input  logic              flt_pin,
    input  logic              cmp1_out,
    input  logic              cmp2_out,
    input  logic              other_brk,
    input  logic              trg_pin,
    input  logic [N_AWD-1:0]  awd_flag,
    output logic              brk_req,
    output logic              ext_trg
);
    brk_cfg_t         wr_cfg;
    brk_cfg_t         cfg_q;
    logic [N_SRC-1:0] raw_lvl;
    logic [N_SRC-1:0] sync_lvl;
    logic             req_d;

    assign wr_cfg  = brk_cfg_t'(wr_data);
    assign rd_data = cfg_q;
    assign raw_lvl = {cmp2_out, cmp1_out, flt_pin};

    brk_cfg_reg #(.LOCK_W(LOCK_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg),
        .lock_lvl(lock_lvl), .cfg_q(cfg_q)
    );

    brk_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lvl), .q(sync_lvl)
    );

    brk_src_cond #(.N(N_SRC)) u_cond (
        .lvl(sync_lvl), .en(cfg_q.en), .inv(cfg_q.inv),
        .glob_pol(glob_pol), .other(other_brk), .req(req_d)
    );

    brk_trg_mux #(.N(N_TRG), .SEL_W(SEL_W)) u_trg (
        .sel(cfg_q.sel), .cand({awd_flag, cmp2_out, cmp1_out, trg_pin}), .trg(ext_trg)
    );

    // Register the merged break request once.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_req <= 1'b0;
        else        brk_req <= req_d;
    end

    // R4: with no source enabled and no external break, the request stays low.
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_q.en) == '0) && !$past(other_brk)) |-> !brk_req);

    // R8: selector code 0 passes the legacy pin.
    p_trg_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sel == '0) |-> (ext_trg == trg_pin));
endmodule

// File: tb/brk_src_merge_tb_top.sv
// Directed bench for the break-source combiner.
module brk_src_merge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FLT_LAT    = 3;   // sync stages + output register

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic [1:0] lock_lvl = '0;
    logic       glob_pol = 1'b0;
    logic       flt_pin = 1'b0, cmp1_out = 1'b0, cmp2_out = 1'b0;
    logic       other_brk = 1'b0;
    logic       trg_pin = 1'b0;
    logic [2:0] awd_flag = '0;
    logic       brk_req, ext_trg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_src_merge dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .lock_lvl(lock_lvl), .glob_pol(glob_pol), .flt_pin(flt_pin), .cmp1_out(cmp1_out),
        .cmp2_out(cmp2_out), .other_brk(other_brk), .trg_pin(trg_pin), .awd_flag(awd_flag),
        .brk_req(brk_req), .ext_trg(ext_trg)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [8:0] d);
        wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic set_faults(logic p, logic c1, logic c2);
        flt_pin = p; cmp1_out = c1; cmp2_out = c2;
    endtask

    // Candidate order: {awd[2:0], cmp2, cmp1, pin}
    task automatic set_trg(logic [5:0] v);
        trg_pin = v[0]; cmp1_out = v[1]; cmp2_out = v[2]; awd_flag = v[5:3];
    endtask

    task automatic t_reset();
        chk("R1 reset register", rd_data, 9'h000);
        chk("R1 reset break", brk_req, 1'b0);
        trg_pin = 1'b1; #1;
        chk("R1 trigger follows pin", ext_trg, 1'b1);
        trg_pin = 1'b0; #1;
        chk("R1 trigger follows pin low", ext_trg, 1'b0);
    endtask

    task automatic t_write_read();
        wr(9'h0A5);
        chk("R2 write stored", rd_data, 9'h0A5);
        wr(9'h15A);
        chk("R2 second write stored", rd_data, 9'h15A);
        wr(9'h000);
    endtask

    task automatic t_disabled();
        wr({3'd0, 3'b111, 3'b000});
        set_faults(1'b1, 1'b1, 1'b1); tick(FLT_LAT);
        chk("R4 disabled high levels", brk_req, 1'b0);
        set_faults(1'b0, 1'b0, 1'b0); tick(FLT_LAT);
        chk("R4 disabled low levels", brk_req, 1'b0);
    endtask

    task automatic t_polarity();
        for (int gp = 0; gp < 2; gp++) begin
            for (int iv = 0; iv < 2; iv++) begin
                logic act;
                act = logic'(gp) ^ logic'(iv);
                glob_pol = logic'(gp);
                set_faults(~act, 1'b0, 1'b0);
                wr({3'd0, 2'b00, logic'(iv), 3'b001});
                tick(FLT_LAT);
                chk($sformatf("R5 inactive gp=%0d inv=%0d", gp, iv), brk_req, 1'b0);
                flt_pin = act; tick(FLT_LAT);
                chk($sformatf("R5 active gp=%0d inv=%0d", gp, iv), brk_req, 1'b1);
            end
        end
        glob_pol = 1'b0;
        set_faults(1'b0, 1'b0, 1'b0);
        wr(9'h000); tick(FLT_LAT);
    endtask

    task automatic t_or_merge();
        wr({3'd0, 3'b111, 3'b111});   // all enabled, active high with glob_pol=0
        tick(FLT_LAT);
        chk("R6 all quiet", brk_req, 1'b0);
        for (int s = 0; s < 3; s++) begin
            set_faults(s == 0, s == 1, s == 2); tick(FLT_LAT);
            chk($sformatf("R6 single source %0d", s), brk_req, 1'b1);
            set_faults(1'b0, 1'b0, 1'b0); tick(FLT_LAT);
            chk($sformatf("R6 source %0d released", s), brk_req, 1'b0);
        end
        other_brk = 1'b1; tick(1);
        chk("R6 R7 other break after one edge", brk_req, 1'b1);
        other_brk = 1'b0; tick(1);
        chk("R7 other break release after one edge", brk_req, 1'b0);
        wr(9'h000);
        other_brk = 1'b1; tick(1);
        chk("R6 other break with sources disabled", brk_req, 1'b1);
        other_brk = 1'b0; tick(1);
    endtask

    task automatic t_latency();
        wr({3'd0, 3'b010, 3'b010});   // comparator 1 only, active high
        tick(FLT_LAT);
        cmp1_out = 1'b1; tick(FLT_LAT - 1);
        chk("R7 not yet at second edge", brk_req, 1'b0);
        tick(1);
        chk("R7 raised at third edge", brk_req, 1'b1);
        cmp1_out = 1'b0; tick(FLT_LAT - 1);
        chk("R7 still high at second edge", brk_req, 1'b1);
        tick(1);
        chk("R7 dropped at third edge", brk_req, 1'b0);
        wr(9'h000);
    endtask

    task automatic t_lock();
        wr(9'h0C3);
        lock_lvl = 2'd1;
        wr(9'h13C);
        chk("R3 R10 lock 1 write ignored", rd_data, 9'h0C3);
        lock_lvl = 2'd3;
        wr(9'h1FF);
        chk("R3 R10 lock 3 write ignored", rd_data, 9'h0C3);
        lock_lvl = 2'd0;
        wr(9'h13C);
        chk("R2 write after unlock", rd_data, 9'h13C);
        wr(9'h000);
    endtask

    task automatic t_trigger();
        for (int code = 0; code < 6; code++) begin
            wr({3'(code), 6'b000000});
            set_trg(6'b000000); #1;
            chk($sformatf("R8 code %0d low", code), ext_trg, 1'b0);
            set_trg(6'(1 << code)); #1;
            chk($sformatf("R8 code %0d selected high", code), ext_trg, 1'b1);
            set_trg(~6'(1 << code)); #1;
            chk($sformatf("R8 code %0d others high", code), ext_trg, 1'b0);
        end
        set_trg(6'b000000);
        wr(9'h000);
    endtask

    task automatic t_reserved();
        wr({3'd4, 6'b000000});
        wr({3'd6, 6'b000101});
        chk("R9 code 6 keeps selector", rd_data, {3'd4, 6'b000101});
        wr({3'd7, 6'b110010});
        chk("R9 code 7 keeps selector", rd_data, {3'd4, 6'b110010});
        set_trg(6'b010000); #1;
        chk("R9 kept selector still routes", ext_trg, 1'b1);
        set_trg(6'b000000);
        wr(9'h000);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_write_read();
        t_disabled();
        t_polarity();
        t_or_merge();
        t_latency();
        t_lock();
        t_trigger();
        t_reserved();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule